// File: doc/BRIEF.md
# Block Cipher Register Front End

This block is the bus-facing shell of a 64-bit block cipher engine that can run with one key or three. Software, or a DMA engine, writes keys, an initial vector and mode bits through a 32-bit register port. It then moves data one block at a time through a two-word data window. The block passes each assembled block to an external cipher core over a start/done port. It latches the result and offers it back through the same window. The cipher arithmetic lives in the core and is not part of this block.

Each block goes through a fixed handshake. The block first signals that it can accept input. After the second input word is written, the core runs. When the core finishes, the block signals that output is available. Once both output words have been read, input readiness returns, as long as the remaining length is not exhausted. The two ready conditions drive sticky status flags, a maskable interrupt and two DMA request lines. Polled and DMA transfers are therefore paced by the same mechanism.

Top module: `blkciph_regs`

## Requirements
- R1: After reset the control, length, status, interrupt enable and DMA mask registers read 0. Both ready flags, `irq`, `dma_in_req`, `dma_out_req` and `core_start` are 0.
- R2: Key word i (i = 0..5) is written at address 0x14 - ((i XOR 1) * 4). Word i appears on `core_key[32*i +: 32]`. Reads of key addresses return 0.
- R3: In the control register at 0x20, bit 4 (chained), bit 3 (triple key) and bit 2 (encrypt when 1) are writable and read back. They drive `core_chain`, `core_triple` and `core_encrypt`. Bit 1 (input ready) and bit 0 (output ready) reflect state, and writes to them are ignored.
- R4: The register at 0x30 reads REV_MAJOR in bits 10:8 and REV_MINOR in bits 5:0, with other bits 0.
- R5: While input is ready, a write to 0x28 sets block bits 31:0. A write to 0x2C sets bits 63:32 and raises `core_start` for exactly one cycle with that block on `core_din`. Input ready then reads 0 until the output has been fully read.
- R6: After `core_done`, output ready is set, and 0x28 and 0x2C read result bits 31:0 and 63:32. Once both have been read, the length at 0x24 drops by 8, output ready clears, and input ready returns if the length is nonzero.
- R7: While the length is 0, input ready stays 0 and data writes launch no core operation.
- R8: At 0x3C, bit 1 is set when input ready rises and bit 2 is set when output ready rises. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R9: `irq` is 1 exactly when a status bit (1 or 2) and the same bit of the enable register at 0x40 are both set.
- R10: In the DMA mask at 0x34, bit 0 starts the transfer, bit 5 enables input requests and bit 6 enables output requests. `dma_in_req` is input ready AND bit 5 AND bit 0. `dma_out_req` is output ready AND bit 6 AND bit 0.
- R11: The IV words at 0x18 (bits 31:0) and 0x1C (bits 63:32) read back and drive `core_iv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (data reads have side effects) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| core_start | output | 1 | One-cycle launch pulse to the cipher core |
| core_din | output | 64 | Block presented to the core |
| core_key | output | 192 | Six key words, word i at bits 32*i+31:32*i |
| core_iv | output | 64 | Initial vector |
| core_encrypt | output | 1 | Direction, 1 means encrypt |
| core_triple | output | 1 | Triple-key mode |
| core_chain | output | 1 | Chained mode |
| core_done | input | 1 | Core result valid pulse |
| core_dout | input | 64 | Core result |
| irq | output | 1 | Interrupt |
| dma_in_req | output | 1 | DMA request for input words |
| dma_out_req | output | 1 | DMA request for output words |

## Verification
The bench targets the swapped, descending key addresses. A design that decoded them linearly would hand the core keys in the wrong order, which shows up at `core_key`. It also covers a launch attempted with zero length, which a careless design would still pass to the core. Status writes that mix 0 and 1 bits are checked, because a design that treated 1 as clear would lose the flag that should survive. Multi-block runs confirm that the length steps by 8 and that input readiness returns only while length remains. DMA requests are checked with the start bit both on and off.

// File: rtl/blkciph_regs.sv
module blkciph_regs #(
  parameter int ADDR_W = 8,
  parameter int LEN_W = 16,
  parameter logic [2:0] REV_MAJOR = 3'd2,
  parameter logic [5:0] REV_MINOR = 6'd9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              core_start,
  output logic [63:0]       core_din,
  output logic [191:0]      core_key,
  output logic [63:0]       core_iv,
  output logic              core_encrypt,
  output logic              core_triple,
  output logic              core_chain,
  input  logic              core_done,
  input  logic [63:0]       core_dout,
  output logic              irq,
  output logic              dma_in_req,
  output logic              dma_out_req
);
  localparam int NKEY = 6;
  localparam logic [ADDR_W-1:0] A_KTOP = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_IV0  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_IV1  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_D0   = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_D1   = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(8'h3C);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h40);
  localparam logic [LEN_W-1:0]  BLK    = LEN_W'(8);

  typedef enum logic [1:0] {PH_IN, PH_RUN, PH_OUT} phase_t;

  logic [31:0] key [NKEY];
  logic [31:0] iv0, iv1;
  logic [2:0] mode;
  logic [LEN_W-1:0] len;
  logic [63:0] din, dout;
  logic [1:0] sts, ien;
  logic dm_go, dm_in, dm_out;
  logic rd0, rd1, in_q, out_q;
  phase_t phase;

  logic in_rdy, out_rdy, len_we, rd0_n, rd1_n;
  assign in_rdy  = (phase == PH_IN) && (len != '0);
  assign out_rdy = (phase == PH_OUT);
  assign len_we  = wr_en && addr == A_LEN;
  assign rd0_n   = rd0 | (rd_en && addr == A_D0);
  assign rd1_n   = rd1 | (rd_en && addr == A_D1);

  function automatic logic [ADDR_W-1:0] key_addr(input int i);
    return A_KTOP - ADDR_W'((i ^ 1) * 4);
  endfunction

  genvar g;
  generate
    for (g = 0; g < NKEY; g++) begin : g_key
      assign core_key[32*g +: 32] = key[g];
    end
  endgenerate

  assign core_din = din;
  assign core_iv = {iv1, iv0};
  assign {core_chain, core_triple, core_encrypt} = mode;
  assign irq = |(sts & ien);
  assign dma_in_req = in_rdy && dm_in && dm_go;
  assign dma_out_req = out_rdy && dm_out && dm_go;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_IV0: rdata = iv0;
        A_IV1: rdata = iv1;
        A_CTL: rdata = {27'd0, mode, in_rdy, out_rdy};
        A_LEN: rdata = 32'(len);
        A_D0:  rdata = dout[31:0];
        A_D1:  rdata = dout[63:32];
        A_REV: rdata = {21'd0, REV_MAJOR, 2'd0, REV_MINOR};
        A_DMA: rdata = {25'd0, dm_out, dm_in, 4'd0, dm_go};
        A_STS: rdata = {29'd0, sts, 1'b0};
        A_IEN: rdata = {29'd0, ien, 1'b0};
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NKEY; i++) key[i] <= '0;
      iv0 <= '0; iv1 <= '0; mode <= '0; len <= '0;
      din <= '0; dout <= '0; sts <= '0; ien <= '0;
      dm_go <= 1'b0; dm_in <= 1'b0; dm_out <= 1'b0;
      rd0 <= 1'b0; rd1 <= 1'b0; in_q <= 1'b0; out_q <= 1'b0;
      core_start <= 1'b0; phase <= PH_IN;
    end else begin
      core_start <= 1'b0;
      in_q <= in_rdy;
      out_q <= out_rdy;
      sts <= ((wr_en && addr == A_STS) ? (sts & wdata[2:1]) : sts)
             | {out_rdy & ~out_q, in_rdy & ~in_q};
      case (phase)
        PH_IN: if (wr_en) begin
          if (addr == A_D0) din[31:0] <= wdata;
          if (addr == A_D1 && in_rdy) begin
            din[63:32] <= wdata;
            core_start <= 1'b1;
            phase <= PH_RUN;
          end
        end
        PH_RUN: if (core_done) begin
          dout <= core_dout;
          rd0 <= 1'b0; rd1 <= 1'b0;
          phase <= PH_OUT;
        end
        default: begin
          rd0 <= rd0_n; rd1 <= rd1_n;
          if (rd0_n && rd1_n) begin
            phase <= PH_IN;
            len <= (len > BLK) ? len - BLK : '0;
          end
        end
      endcase
      if (wr_en) begin
        for (int i = 0; i < NKEY; i++)
          if (addr == key_addr(i)) key[i] <= wdata;
        case (addr)
          A_IV0: iv0 <= wdata;
          A_IV1: iv1 <= wdata;
          A_CTL: mode <= wdata[4:2];
          A_LEN: len <= wdata[LEN_W-1:0];
          A_DMA: {dm_out, dm_in, dm_go} <= {wdata[6], wdata[5], wdata[0]};
          A_IEN: ien <= wdata[2:1];
          default: ;
        endcase
      end
    end
  end
endmodule

module blkciph_regs_chk #(parameter int LEN_W = 16) (
  input logic clk,
  input logic rst_n,
  input logic in_rdy,
  input logic out_rdy,
  input logic core_start,
  input logic [1:0] sts,
  input logic [LEN_W-1:0] len,
  input logic len_we,
  input logic dma_in_req
);
  AST_START_AFTER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(in_rdy)); // R5
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start); // R5
  AST_RDY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_rdy && out_rdy)); // R6
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_rdy) && !$past(len_we)) |->
      (len == (($past(len) > LEN_W'(8)) ? $past(len) - LEN_W'(8) : '0))); // R6
  AST_OUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |=> sts[1]); // R8
  AST_ZERO_LEN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (len == '0) |-> !dma_in_req); // R7
endmodule

bind blkciph_regs blkciph_regs_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .out_rdy(out_rdy),
  .core_start(core_start), .sts(sts), .len(len), .len_we(len_we),
  .dma_in_req(dma_in_req));

// File: tb/tb_blkciph_regs.sv
module tb_blkciph_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic core_start, core_encrypt, core_triple, core_chain;
  logic [63:0] core_din, core_iv;
  logic [191:0] core_key;
  logic core_done = 0;
  logic [63:0] core_dout = 0;
  logic irq, dma_in_req, dma_out_req;

  int checks = 0, errors = 0, starts = 0, lat = 0;
  logic [63:0] got_din = 0;
  logic [31:0] kw [6];

  always #4 clk = ~clk;

  blkciph_regs dut (.*);

  always @(negedge clk) begin
    core_done <= 1'b0;
    if (core_start) begin
      starts <= starts + 1;
      got_din <= core_din;
      lat <= 3;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        core_done <= 1'b1;
        core_dout <= got_din ^ core_key[63:0] ^ core_key[191:128]
                     ^ {61'd0, core_chain, core_triple, core_encrypt};
      end
    end
  end

  localparam logic [66:0] VEC [6] = '{
    {64'h0123_4567_89AB_CDEF, 3'b001}, {64'hFFFF_FFFF_0000_0000, 3'b000},
    {64'h0000_0000_0000_0001, 3'b011}, {64'hDEAD_BEEF_CAFE_F00D, 3'b111},
    {64'h8000_0000_0000_0000, 3'b100}, {64'h5A5A_A5A5_3C3C_C3C3, 3'b010}};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_out();
    logic [31:0] c;
    for (int i = 0; i < 40; i++) begin
      rd(8'h20, c);
      if (c[0]) return;
    end
    check("R6 output ready timeout", 0, 1);
  endtask

  function automatic logic [63:0] model(input logic [63:0] d, input logic [2:0] m);
    return d ^ {kw[1], kw[0]} ^ {kw[5], kw[4]} ^ {61'd0, m};
  endfunction

  initial begin
    #(8 * 150000);
    check("watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, lo, hi;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h20, r); check("R1 ctrl", r, 0);
    rd(8'h24, r); check("R1 len", r, 0);
    rd(8'h3C, r); check("R1 sts", r, 0);
    rd(8'h34, r); check("R1 dma mask", r, 0);
    check("R1 outputs", {irq, dma_in_req, dma_out_req, core_start}, 0);
    // R4 revision
    rd(8'h30, r); check("R4 revision", r, 32'h0000_0209);
    // R2 keys at swapped descending addresses
    for (int i = 0; i < 6; i++) begin
      kw[i] = 32'hA5A5_0000 + i * 32'h0101_0103;
      wr(8'h14 - 8'((i ^ 1) * 4), kw[i]);
    end
    check("R2 core_key", core_key, {kw[5], kw[4], kw[3], kw[2], kw[1], kw[0]});
    rd(8'h10, r); check("R2 key read zero", r, 0);
    // R11 IV
    wr(8'h18, 32'h1357_9BDF); wr(8'h1C, 32'h2468_ACE0);
    rd(8'h1C, r); check("R11 iv readback", r, 32'h2468_ACE0);
    check("R11 core_iv", core_iv, 64'h2468_ACE0_1357_9BDF);
    // R3 control
    wr(8'h20, 32'h1F);
    rd(8'h20, r); check("R3 ctrl readback ignores bits 1:0", r, 32'h1C);
    check("R3 mode outputs", {core_chain, core_triple, core_encrypt}, 3'b111);
    // R7 zero length
    s0 = starts;
    wr(8'h28, 32'h1); wr(8'h2C, 32'h2);
    repeat (6) @(negedge clk);
    check("R7 no launch at zero length", starts, s0);
    // R5/R6/R7 vector table
    foreach (VEC[v]) begin
      wr(8'h20, {27'd0, VEC[v][2:0], 2'b00});
      wr(8'h24, 8);
      rd(8'h20, r); check("R5 input ready", r, {27'd0, VEC[v][2:0], 2'b10});
      s0 = starts;
      wr(8'h28, VEC[v][34:3]); wr(8'h2C, VEC[v][66:35]);
      rd(8'h20, r); check("R5 input ready dropped", r[1], 0);
      check("R5 one launch", starts, s0 + 1);
      check("R5 core_din", got_din, VEC[v][66:3]);
      wait_out();
      rd(8'h28, lo); rd(8'h2C, hi);
      check("R6 result", {hi, lo}, model(VEC[v][66:3], VEC[v][2:0]));
      rd(8'h24, r); check("R6 length step", r, 0);
      rd(8'h20, r); check("R7 no input ready at zero", r[1:0], 0);
    end
    // R8/R9 multi-block
    wr(8'h20, 0); wr(8'h3C, 0); wr(8'h40, 0);
    wr(8'h24, 16);
    wr(8'h28, 32'h11); wr(8'h2C, 32'h22);
    wait_out();
    rd(8'h2C, hi); rd(8'h28, lo);
    check("R6 result reverse read order", {hi, lo}, model(64'h22_0000_0011, 0));
    rd(8'h24, r); check("R6 length 16 to 8", r, 8);
    rd(8'h20, r); check("R6 input ready returns", r[1:0], 2'b10);
    rd(8'h3C, r); check("R8 both flags set", r, 32'h6);
    wr(8'h3C, 32'h4);
    rd(8'h3C, r); check("R8 write0 clears, write1 keeps", r, 32'h4);
    check("R9 irq disabled", irq, 0);
    wr(8'h40, 32'h4);
    check("R9 irq enabled", irq, 1);
    wr(8'h3C, 0);
    check("R9 irq after clear", irq, 0);
    wr(8'h28, 32'h33); wr(8'h2C, 32'h44);
    wait_out();
    check("R9 irq on output ready", irq, 1);
    rd(8'h28, lo); rd(8'h2C, hi);
    rd(8'h24, r); check("R6 length 8 to 0", r, 0);
    wr(8'h3C, 0); wr(8'h40, 0);
    // R10 DMA
    wr(8'h34, 32'h60); wr(8'h24, 8);
    check("R10 no request without start bit", dma_in_req, 0);
    wr(8'h34, 32'h61);
    rd(8'h34, r); check("R10 mask readback", r, 32'h61);
    check("R10 input request", {dma_in_req, dma_out_req}, 2'b10);
    wr(8'h28, 32'h5); wr(8'h2C, 32'h6);
    check("R10 input request drops", dma_in_req, 0);
    wait_out();
    check("R10 output request", {dma_in_req, dma_out_req}, 2'b01);
    rd(8'h28, lo); rd(8'h2C, hi);
    check("R10 requests idle at end", {dma_in_req, dma_out_req}, 2'b00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule